// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical address using segment descriptors stored in memory. A logical address has two parts: a segment number and a byte displacement. Two descriptor tables live in memory, one for user-mode code and one for system-mode code. Each table has its own base-address register and its own entry-count register. The block adds the segment number times the entry size to the selected table base, then fetches that descriptor over a simple read port. It adds the displacement to the segment base held in the descriptor, and it checks the displacement against the segment limit. The translated address or a fault code comes back on a response channel.

The table registers are loaded through a separate port. A load takes effect only when it is marked privileged, so user code cannot redirect its own translations. Each descriptor is 8 bytes: a 32-bit segment base at the entry address and a 32-bit segment limit four bytes above it. The block fetches these as two read transactions, one after the other. Only one translation is in flight at a time.

The controller has six states:
- `ST_IDLE` takes a request. It goes to `ST_RESP` on a privilege or selector fault, and to `ST_BASE_REQ` otherwise.
- `ST_BASE_REQ` issues the base read. It moves on to `ST_BASE_WAIT` when the read port accepts.
- `ST_BASE_WAIT` captures the base word when the read data returns, then goes to `ST_LIM_REQ`.
- `ST_LIM_REQ` issues the limit read. It moves on to `ST_LIM_WAIT` when the read port accepts.
- `ST_LIM_WAIT` does the bounds check when the read data returns, then goes to `ST_RESP`.
- `ST_RESP` presents the result. It returns to `ST_IDLE` once the response is consumed.

Top module: `seg_xlate`

## Requirements
- R1: A translation that passes the selector check issues exactly two reads. The first read is at the table base plus the segment number times 8, and its data is the segment base. The second read is at that address plus 4, and its data is the segment limit.
- R2: When the displacement is less than or equal to the limit (equality allowed), the response carries fault code 0 and physical address = segment base + displacement, modulo 2^32.
- R3: When the displacement exceeds the limit, the response carries fault code 1 and a physical address of 0.
- R4: When the segment number is greater than or equal to the selected table's entry count, the response carries fault code 2 and a physical address of 0, and no memory read is issued.
- R5: `req_sys`=1 selects the system table and `req_sys`=0 selects the user table. A request with `req_sys`=1 and `req_priv`=0 gets fault code 3 and a physical address of 0, and no memory read is issued.
- R6: A load with `ld_priv`=1 writes the base and the count of the table chosen by `ld_sys` (1 = system). A load with `ld_priv`=0 changes nothing.
- R7: After reset, both bases and both counts are zero, so every translation returns fault code 2 until a table is loaded.
- R8: `req_ready` is high only while no translation is outstanding. `rsp_valid` stays high, with its address and fault code stable, until `rsp_ready` is seen.
- R9: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address stay unchanged.
- R10: When several faults apply, fault code 3 takes priority over code 2, and code 2 takes priority over code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_sys | input | 1 | 1 = use system table, 0 = user table |
| req_priv | input | 1 | 1 = requester runs in system mode |
| req_seg | input | SEG_W | Segment number |
| req_disp | input | ADDR_W | Displacement within the segment |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | ADDR_W | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 limit, 2 selector, 3 privilege |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | ADDR_W | Descriptor word byte address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | ADDR_W | Read data |
| ld_valid | input | 1 | Table register load strobe |
| ld_priv | input | 1 | Load is privileged |
| ld_sys | input | 1 | 1 = load system table, 0 = user table |
| ld_base | input | ADDR_W | New table base |
| ld_count | input | SEG_W+1 | New entry count |

## Verification
Assertions check four things on every cycle:
- Unprivileged loads leave both register pairs unchanged.
- Both the response and the read request hold steady under back-pressure.
- `req_ready` and `rsp_valid` are never high together.
- A faulting response never carries a nonzero address.

Other behaviour needs the bench's scenarios to show it:
- The descriptor addresses that are actually fetched.
- The sum of base and displacement.
- The equal-to-limit boundary.
- The fault priority order.
- Translations that fault before any table has been loaded.

The bench checks these against a reference model and a memory model that counts reads.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_LIMIT    = 2'd1,
        FLT_SELECTOR = 2'd2,
        FLT_PRIV     = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE_REQ,
        ST_BASE_WAIT,
        ST_LIM_REQ,
        ST_LIM_WAIT,
        ST_RESP
    } state_e;

endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs #(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_priv,
    input  logic              ld_sys,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [SEG_W:0]    ld_count,
    output logic [ADDR_W-1:0] usr_base,
    output logic [SEG_W:0]    usr_count,
    output logic [ADDR_W-1:0] sys_base,
    output logic [SEG_W:0]    sys_count
);
    localparam int NUM_TABLES = 2;

    logic [ADDR_W-1:0] base_q [NUM_TABLES];
    logic [SEG_W:0]    cnt_q  [NUM_TABLES];

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[t] <= '0;
                cnt_q[t]  <= '0;
            end else if (ld_valid && ld_priv && (ld_sys == (t == 1))) begin
                base_q[t] <= ld_base;
                cnt_q[t]  <= ld_count;
            end
        end
    end

    assign usr_base  = base_q[0];
    assign usr_count = cnt_q[0];
    assign sys_base  = base_q[1];
    assign sys_count = cnt_q[1];

    // R6: an unprivileged load leaves both tables untouched
    a_r6_unpriv_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_priv) |=> ($stable(usr_base) && $stable(usr_count)
                                    && $stable(sys_base) && $stable(sys_count)));

    // R6: a privileged load to one table never disturbs the other
    a_r6_other_table_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_priv && ld_sys) |=> ($stable(usr_base) && $stable(usr_count)));

endmodule

// File: rtl/seg_sel_check.sv
module seg_sel_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SEG_W       = 8,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic              sel_sys,
    input  logic              sel_priv,
    input  logic [SEG_W-1:0]  sel_seg,
    input  logic [ADDR_W-1:0] usr_base,
    input  logic [SEG_W:0]    usr_count,
    input  logic [ADDR_W-1:0] sys_base,
    input  logic [SEG_W:0]    sys_count,
    output logic [ADDR_W-1:0] entry_addr,
    output fault_e            pre_fault
);
    logic [ADDR_W-1:0] tbl_base;
    logic [SEG_W:0]    tbl_count;

    always_comb begin
        tbl_base   = sel_sys ? sys_base  : usr_base;
        tbl_count  = sel_sys ? sys_count : usr_count;
        entry_addr = tbl_base + (ADDR_W'(sel_seg) << ENTRY_SHIFT);
        if (sel_sys && !sel_priv)
            pre_fault = FLT_PRIV;
        else if ({1'b0, sel_seg} >= tbl_count)
            pre_fault = FLT_SELECTOR;
        else
            pre_fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlate_fsm.sv
module seg_xlate_fsm
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_disp,
    input  logic [ADDR_W-1:0] entry_addr,
    input  fault_e            pre_fault,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int WORD_BYTES = ADDR_W / 8;

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] entry_q, disp_q, seg_base_q, paddr_q;
    fault_e            fault_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid)
                              state_d = (pre_fault != FLT_NONE) ? ST_RESP : ST_BASE_REQ;
            ST_BASE_REQ:  if (mem_rd_ready)  state_d = ST_BASE_WAIT;
            ST_BASE_WAIT: if (mem_rsp_valid) state_d = ST_LIM_REQ;
            ST_LIM_REQ:   if (mem_rd_ready)  state_d = ST_LIM_WAIT;
            ST_LIM_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
            ST_RESP:      if (rsp_ready)     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q    <= '0;
            disp_q     <= '0;
            seg_base_q <= '0;
            paddr_q    <= '0;
            fault_q    <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    entry_q <= entry_addr;
                    disp_q  <= req_disp;
                    fault_q <= pre_fault;
                    paddr_q <= '0;
                end
                ST_BASE_WAIT: if (mem_rsp_valid) seg_base_q <= mem_rsp_data;
                ST_LIM_WAIT: if (mem_rsp_valid) begin
                    if (disp_q <= mem_rsp_data) begin
                        fault_q <= FLT_NONE;
                        paddr_q <= seg_base_q + disp_q;
                    end else begin
                        fault_q <= FLT_LIMIT;
                        paddr_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        rsp_paddr    = paddr_q;
        rsp_fault    = fault_q;
        mem_rd_valid = (state_q == ST_BASE_REQ) || (state_q == ST_LIM_REQ);
        mem_rd_addr  = (state_q == ST_LIM_REQ) ? entry_q + ADDR_W'(WORD_BYTES) : entry_q;
    end

    // R8: one translation outstanding; response waits for the consumer
    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid);
    a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R9: stalled read request keeps its address
    a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R3: a faulting response carries a zero address
    a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_sys,
    input  logic              req_priv,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_disp,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              ld_valid,
    input  logic              ld_priv,
    input  logic              ld_sys,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [SEG_W:0]    ld_count
);
    localparam int WORD_BYTES  = ADDR_W / 8;
    localparam int ENTRY_BYTES = 2 * WORD_BYTES;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] usr_base, sys_base, entry_addr;
    logic [SEG_W:0]    usr_count, sys_count;
    fault_e            pre_fault;

    seg_table_regs #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_priv(ld_priv), .ld_sys(ld_sys),
        .ld_base(ld_base), .ld_count(ld_count),
        .usr_base(usr_base), .usr_count(usr_count),
        .sys_base(sys_base), .sys_count(sys_count)
    );

    seg_sel_check #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_check (
        .sel_sys(req_sys), .sel_priv(req_priv), .sel_seg(req_seg),
        .usr_base(usr_base), .usr_count(usr_count),
        .sys_base(sys_base), .sys_count(sys_count),
        .entry_addr(entry_addr), .pre_fault(pre_fault)
    );

    seg_xlate_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_disp(req_disp),
        .entry_addr(entry_addr), .pre_fault(pre_fault),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
    localparam int AW = 32;
    localparam int SW = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0, req_sys = 0, req_priv = 0;
    logic [SW-1:0] req_seg = '0;
    logic [AW-1:0] req_disp = '0;
    logic          rsp_ready = 0;
    logic          mem_rd_ready = 0, mem_rsp_valid = 0;
    logic [AW-1:0] mem_rsp_data = '0;
    logic          ld_valid = 0, ld_priv = 0, ld_sys = 0;
    logic [AW-1:0] ld_base = '0;
    logic [SW:0]   ld_count = '0;
    logic          req_ready, rsp_valid, mem_rd_valid;
    logic [AW-1:0] rsp_paddr, mem_rd_addr;
    logic [1:0]    rsp_fault;

    int checks = 0, failures = 0;
    int nreads = 0;
    logic [AW-1:0] rd_log [2];
    logic          hs_flag = 0;
    logic [AW-1:0] hs_addr = '0;
    logic [AW-1:0] m_base [2];
    logic [SW:0]   m_cnt  [2];
    bit            done = 0;

    always #4 clk = ~clk;

    seg_xlate #(.ADDR_W(AW), .SEG_W(SW)) uut (.*);

    function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
        logic [AW-1:0] h;
        h = (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
        return a[2] ? (h & 32'h0000_FFFF) : h;
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with random acceptance stalls
    initial begin
        forever begin
            @(negedge clk);
            if (hs_flag) begin
                mem_rsp_valid = 1;
                mem_rsp_data  = mem_word(hs_addr);
                hs_flag = 0;
            end else begin
                mem_rsp_valid = 0;
            end
            mem_rd_ready = ($urandom % 4) != 0;
            if (mem_rd_valid && mem_rd_ready) begin
                hs_flag = 1;
                hs_addr = mem_rd_addr;
                if (nreads < 2) rd_log[nreads] = mem_rd_addr;
                nreads++;
            end
        end
    end

    task automatic load(input logic priv, input logic sys, input logic [AW-1:0] b, input logic [SW:0] c);
        @(negedge clk);
        ld_valid = 1; ld_priv = priv; ld_sys = sys; ld_base = b; ld_count = c;
        @(negedge clk);
        ld_valid = 0;
        if (priv) begin
            m_base[sys] = b;
            m_cnt[sys]  = c;
        end
    endtask

    task automatic xlate(input logic sys, input logic priv, input logic [SW-1:0] seg,
                         input logic [AW-1:0] disp, input string tag);
        logic [1:0]    e_fault;
        logic [AW-1:0] e_paddr, entry, lim;
        logic [AW-1:0] held_p;
        logic [1:0]    held_f;
        int            wait_n;
        // reference model: privilege, then selector, then limit (R10)
        entry = m_base[sys] + ({24'd0, seg} << 3);
        lim   = mem_word(entry + 4);
        if (sys && !priv)                     begin e_fault = 2'd3; e_paddr = '0; end
        else if ({1'b0, seg} >= m_cnt[sys])   begin e_fault = 2'd2; e_paddr = '0; end
        else if (disp <= lim)                 begin e_fault = 2'd0; e_paddr = mem_word(entry) + disp; end
        else                                  begin e_fault = 2'd1; e_paddr = '0; end

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nreads = 0;
        req_valid = 1; req_sys = sys; req_priv = priv; req_seg = seg; req_disp = disp;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        // R8: hold the response back and confirm it stays put
        held_p = rsp_paddr; held_f = rsp_fault;
        wait_n = $urandom % 3;
        for (int i = 0; i < wait_n; i++) begin
            @(negedge clk);
            chk({"R8 rsp hold ", tag}, {rsp_valid, rsp_fault, rsp_paddr[28:0]},
                {1'b1, held_f, held_p[28:0]});
        end
        chk({"R2/R3 paddr ", tag}, rsp_paddr, e_paddr);
        chk({"R10 fault ", tag}, {30'd0, rsp_fault}, {30'd0, e_fault});
        if (e_fault >= 2'd2) begin
            chk({"R4/R5 no read ", tag}, nreads, 0);
        end else begin
            chk({"R1 read count ", tag}, nreads, 2);
            chk({"R1 base addr ", tag}, rd_log[0], entry);
            chk({"R1 limit addr ", tag}, rd_log[1], entry + 4);
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk({"R8 rsp cleared ", tag}, {31'd0, rsp_valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] lim, ent;
        void'($urandom(32'd1234));
        m_base[0] = '0; m_base[1] = '0; m_cnt[0] = '0; m_cnt[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset ready", {31'd0, req_ready}, 1);
        chk("R8 reset rsp", {31'd0, rsp_valid}, 0);
        chk("R9 reset no read", {31'd0, mem_rd_valid}, 0);

        // R7: tables empty after reset
        xlate(0, 0, 8'd0, 32'd0, "R7 user empty");
        xlate(1, 1, 8'd0, 32'd0, "R7 sys empty");

        // R6: unprivileged loads are refused
        load(0, 0, 32'h0000_1000, 9'd16);
        load(0, 1, 32'h0000_8000, 9'd64);
        xlate(0, 0, 8'd1, 32'd4, "R6 unpriv user ignored");
        xlate(1, 1, 8'd1, 32'd4, "R6 unpriv sys ignored");

        load(1, 0, 32'h0000_1000, 9'd16);
        load(1, 1, 32'h0008_0000, 9'd64);

        // R2/R3 limit boundaries
        ent = 32'h0000_1000 + (32'd3 << 3);
        lim = mem_word(ent + 4);
        xlate(0, 0, 8'd3, lim, "R2 disp equals limit");
        xlate(0, 0, 8'd3, lim + 1, "R3 disp above limit");
        xlate(0, 0, 8'd3, 32'd0, "R2 zero disp");
        xlate(0, 0, 8'd15, 32'd7, "R4 last valid seg");
        xlate(0, 0, 8'd16, 32'd7, "R4 seg equals count");
        xlate(1, 1, 8'd63, 32'd9, "R5 sys table");
        xlate(1, 0, 8'd2, 32'd9, "R5 user to sys");
        xlate(1, 0, 8'd200, 32'hFFFF_FFFF, "R10 priv over selector");
        xlate(0, 0, 8'd200, 32'hFFFF_FFFF, "R10 selector over limit");
        xlate(0, 1, 8'd5, 32'd1, "R5 priv uses user table");

        // R6: refused reload keeps old mapping
        load(0, 0, 32'h0040_0000, 9'd256);
        xlate(0, 0, 8'd20, 32'd1, "R6 refused count");
        xlate(0, 0, 8'd4, 32'd2, "R6 refused base");

        // constrained random mix
        for (int n = 0; n < 150; n++) begin
            logic s, p;
            logic [SW-1:0] sg;
            logic [AW-1:0] d, e;
            s  = $urandom % 2;
            p  = ($urandom % 4) != 0;
            sg = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
            e  = m_base[s] + ({24'd0, sg} << 3);
            case ($urandom % 3)
                0: d = mem_word(e + 4) + 32'($urandom % 3) - 32'd1;
                1: d = $urandom % 32'h0002_0000;
                default: d = $urandom;
            endcase
            xlate(s, p, sg, d, "random");
            if (n == 75) load(1, 1, 32'h0010_0008, 9'd32);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule